// File: doc/BRIEF.md
# Strap-Configured Management Address Decoder and Indirect Bridge

This block sits on the switch side of a management bus and handles transactions that have already been deframed. Each transaction carries a 5-bit bus address, a 5-bit register number, a read/write flag and 16 bits of write data. The block decides from static strap inputs whether it owns the transaction. It answers every transaction one cycle later with a response strobe and read data.

The straps select one of three address maps. In the first, the block owns the whole bus and each bus address goes straight to the internal device with that number. In the second, it owns one half of the bus, so two such devices can share a single bus. In the third, it owns only a two-register window at an even base address. Software reaches internal devices through that window: it loads a data register, then writes a command word that has a busy flag. The block clears the flag once the internal access has finished.

A register-file model of 32 internal devices with 32 registers each stands in for the internal register bus.

Top module: `mgmt_bridge`

## Requirements
- R1: With `split_en` low and `strap_addr` equal to zero, every bus address is claimed, and bus address N reads and writes register R of internal device N.
- R2: With `split_en` high, only `strap_addr[3]` is used. Bus addresses whose bit 4 equals `strap_addr[3]` are claimed, and each one reaches internal device (bus address minus base), where the base is `strap_addr[3]` times 16.
- R3: With `split_en` low and `strap_addr` non-zero, the base is `{strap_addr, 1'b0}`. Only register 0 (command) and register 1 (data) at the base address are claimed. Other bus addresses and other registers at the base cannot reach any internal device.
- R4: An unclaimed transaction responds with 0xFFFF and changes no state. This covers internal device registers, the command register and the data register.
- R5: Every request produces exactly one `rsp_valid` pulse on the following cycle, and nothing else does. A claimed write responds with 0x0000. After reset, `rsp_valid` is low and the command and data registers read 0x0000.
- R6: In the command word, bits 9:5 give the internal device and bits 4:0 give the internal register. Bit 12 marks a clause-22 command. Bits 11:10 give the opcode: 01 is write and 10 is read.
- R7: Bit 15 of the command register is busy. It reads back as 1 for exactly ACC_LAT cycles after the command write that started the operation, and then reads 0. Bits 14:0 read back as written.
- R8: An indirect write stores the data register contents into the addressed internal register when the operation completes.
- R9: An indirect read places the addressed internal register into the data register in the same cycle that busy clears.
- R10: A command write that arrives while busy is set is ignored. The stored command, the data register and the internal registers are left as they were.
- R11: A command with bit 12 clear, or with opcode 00 or 11, runs through the same busy timing but touches neither the internal registers nor the data register.
- R12: A command write with bit 15 clear starts nothing and leaves the command register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 4 | Strapped bus address bits 4:1 |
| split_en | input | 1 | Selects the half-bus (two devices per bus) map |
| req_valid | input | 1 | Transaction strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Bus device address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 16 | Read data (0xFFFF if unclaimed, 0x0000 for a claimed write) |

## Verification
In the half-bus test, the bench writes through an upper-half address and reads the value back through the direct map at the reduced device number. A decoder that skipped the subtraction would put the value at the wrong device. The bench polls the busy bit on every cycle after a command, so a latency counter that is off by one cycle shows up as a mismatch on the boundary poll. It also reads the data register on the same cycle that busy first reads 0, which catches a read result that lands late. Three further stimuli each leave a visible trace if mishandled: a second command issued while busy, a non-clause-22 or reserved opcode, and a command written without bit 15. Each would change the command readback or overwrite the data register.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [1:0] {
    MAP_DIRECT   = 2'd0,
    MAP_SPLIT    = 2'd1,
    MAP_INDIRECT = 2'd2
  } map_mode_e;

  localparam int CMD_BUSY_BIT = 15;
  localparam int CMD_C22_BIT  = 12;
  localparam int CMD_OP_LSB   = 10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

endpackage

// File: rtl/mgmt_addr_decode.sv
module mgmt_addr_decode
  import mgmt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 5
) (
  input  logic [ADDR_W-2:0] strap_addr,
  input  logic              split_en,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [REG_W-1:0]  req_reg,
  output map_mode_e         map_mode,
  output logic              claim,
  output logic [ADDR_W-1:0] int_dev,
  output logic              win_data
);

  localparam int WIN_REGS = 2;
  localparam int MSB      = ADDR_W - 1;

  always_comb begin
    if (split_en)
      map_mode = MAP_SPLIT;
    else if (strap_addr == '0)
      map_mode = MAP_DIRECT;
    else
      map_mode = MAP_INDIRECT;
  end

  always_comb begin
    claim    = 1'b0;
    int_dev  = req_phy;
    win_data = req_reg[0];
    unique case (map_mode)
      MAP_DIRECT: begin
        claim = 1'b1;
      end
      MAP_SPLIT: begin
        claim   = (req_phy[MSB] == strap_addr[MSB-1]);
        int_dev = {1'b0, req_phy[MSB-1:0]};
      end
      default: begin
        claim = (req_phy[MSB:1] == strap_addr) && !req_phy[0] &&
                (req_reg < REG_W'(WIN_REGS));
      end
    endcase
  end

endmodule

// File: rtl/mgmt_ind_engine.sv
module mgmt_ind_engine
  import mgmt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEV_W   = 5,
  parameter int REG_W   = 5,
  parameter int ACC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              busy,
  output logic [DATA_W-2:0] cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic              acc_fire,
  output logic              acc_we,
  output logic [DEV_W-1:0]  acc_dev,
  output logic [REG_W-1:0]  acc_reg
);

  localparam int CNT_W = (ACC_LAT < 2) ? 1 : $clog2(ACC_LAT);

  logic              busy_n;
  logic [DATA_W-2:0] cmd_n;
  logic [DATA_W-1:0] data_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [1:0]        op;
  logic              is_c22, done;

  assign op      = cmd_q[CMD_OP_LSB +: 2];
  assign is_c22  = cmd_q[CMD_C22_BIT];
  assign done    = busy && (cnt_q == '0);
  assign acc_fire = done && is_c22 && ((op == OP_WRITE) || (op == OP_READ));
  assign acc_we   = acc_fire && (op == OP_WRITE);
  assign acc_dev  = cmd_q[REG_W +: DEV_W];
  assign acc_reg  = cmd_q[REG_W-1:0];

  always_comb begin
    busy_n = busy;
    cmd_n  = cmd_q;
    data_n = data_q;
    cnt_n  = cnt_q;
    if (wr_data)
      data_n = wdata;
    if (busy) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        if (acc_fire && !acc_we)
          data_n = rf_rdata;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end else if (wr_cmd && wdata[CMD_BUSY_BIT]) begin
      busy_n = 1'b1;
      cmd_n  = wdata[DATA_W-2:0];
      cnt_n  = CNT_W'(ACC_LAT - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy   <= busy_n;
      cmd_q  <= cmd_n;
      data_q <= data_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile #(
  parameter int DATA_W = 16,
  parameter int DEV_W  = 5,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DEV_W-1:0]  dev,
  input  logic [REG_W-1:0]  rsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = DEV_W + REG_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx   = {dev, rsel};
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we)
      mem[idx] <= wdata;
  end

endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge
  import mgmt_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int ACC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-2:0] strap_addr,
  input  logic              split_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  map_mode_e         map_mode;
  logic              claim, win_data, mode_ind;
  logic [ADDR_W-1:0] dir_dev;
  logic              wr_cmd, wr_data, dir_we;
  logic              busy, acc_fire, acc_we;
  logic [DATA_W-2:0] cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] acc_dev;
  logic [REG_W-1:0]  acc_reg;
  logic              rf_we;
  logic [ADDR_W-1:0] rf_dev;
  logic [REG_W-1:0]  rf_reg;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;
  logic [DATA_W-1:0] rsp_n;

  mgmt_addr_decode #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_dec (
    .strap_addr (strap_addr),
    .split_en   (split_en),
    .req_phy    (req_phy),
    .req_reg    (req_reg),
    .map_mode   (map_mode),
    .claim      (claim),
    .int_dev    (dir_dev),
    .win_data   (win_data)
  );

  assign mode_ind = (map_mode == MAP_INDIRECT);
  assign wr_cmd   = req_valid && req_write && claim && mode_ind && !win_data;
  assign wr_data  = req_valid && req_write && claim && mode_ind &&  win_data;
  assign dir_we   = req_valid && req_write && claim && !mode_ind;

  mgmt_ind_engine #(
    .DATA_W (DATA_W), .DEV_W (ADDR_W), .REG_W (REG_W), .ACC_LAT (ACC_LAT)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (wr_cmd),
    .wr_data  (wr_data),
    .wdata    (req_wdata),
    .rf_rdata (rf_rdata),
    .busy     (busy),
    .cmd_q    (cmd_q),
    .data_q   (data_q),
    .acc_fire (acc_fire),
    .acc_we   (acc_we),
    .acc_dev  (acc_dev),
    .acc_reg  (acc_reg)
  );

  always_comb begin
    if (busy) begin
      rf_we    = acc_we;
      rf_dev   = acc_dev;
      rf_reg   = acc_reg;
      rf_wdata = data_q;
    end else begin
      rf_we    = dir_we;
      rf_dev   = dir_dev;
      rf_reg   = req_reg;
      rf_wdata = req_wdata;
    end
  end

  mgmt_regfile #(.DATA_W(DATA_W), .DEV_W(ADDR_W), .REG_W(REG_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .dev   (rf_dev),
    .rsel  (rf_reg),
    .wdata (rf_wdata),
    .rdata (rf_rdata)
  );

  always_comb begin
    if (!claim)
      rsp_n = '1;
    else if (req_write)
      rsp_n = '0;
    else if (mode_ind)
      rsp_n = win_data ? data_q : {busy, cmd_q};
    else
      rsp_n = rf_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid)
        rsp_rdata <= rsp_n;
    end
  end

endmodule

// File: rtl/mgmt_bridge_chk.sv
module mgmt_bridge_chk #(
  parameter int DATA_W  = 16,
  parameter int ACC_LAT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              claim,
  input logic              mode_ind,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              busy,
  input logic [DATA_W-2:0] cmd_q,
  input logic              rf_we
);

  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_len <= '0;
    else if (busy)
      run_len <= run_len + 16'd1;
    else
      run_len <= '0;
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R5
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R5
  AST_UNCLAIMED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !claim) |=> (rsp_rdata == '1)); // R4
  AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 16'(ACC_LAT))); // R7
  AST_BUSY_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 16'(ACC_LAT))); // R7
  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q)); // R10
  AST_IND_WRITE_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && mode_ind) |-> busy); // R8

endmodule

bind mgmt_bridge mgmt_bridge_chk #(.DATA_W(DATA_W), .ACC_LAT(ACC_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .claim     (claim),
  .mode_ind  (mode_ind),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .busy      (busy),
  .cmd_q     (cmd_q),
  .rf_we     (rf_we)
);

// File: tb/mgmt_bridge_tb.sv
`timescale 1ns/1ps
module mgmt_bridge_tb;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  strap_addr;
  logic        split_en;
  logic        req_valid;
  logic        req_write;
  logic [4:0]  req_phy;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mgmt_bridge #(.ACC_LAT(LAT)) u_dut (
    .clk (clk), .rst_n (rst_n), .strap_addr (strap_addr), .split_en (split_en),
    .req_valid (req_valid), .req_write (req_write), .req_phy (req_phy),
    .req_reg (req_reg), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata)
  );

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issues one request per call and queues the expected response
  task automatic req(bit w, logic [4:0] p, logic [4:0] r, logic [15:0] d,
                     logic [15:0] e, string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_phy   = p;
    req_reg   = r;
    req_wdata = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic set_map(bit s, logic [3:0] a);
    idle(1);
    split_en   = s;
    strap_addr = a;
    idle(1);
  endtask

  // monitor: compares each response against the oldest queued expectation
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected response", rsp_rdata, 16'h0000);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_phy = '0;
    req_reg = '0; req_wdata = '0; strap_addr = '0; split_en = 1'b0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R5 reset rsp_valid", {15'd0, rsp_valid}, 16'h0);
    rst_n = 1'b1;
    idle(1);

    // R1: full direct map
    req(1, 5'd3,  5'd7,  16'hA5A5, 16'h0000, "R1 write d3");
    req(1, 5'd31, 5'd0,  16'h1357, 16'h0000, "R1 write d31");
    req(1, 5'd0,  5'd31, 16'h0F0F, 16'h0000, "R1 write d0");
    req(1, 5'd7,  5'd2,  16'hC0DE, 16'h0000, "R1 write d7");
    req(0, 5'd3,  5'd7,  16'h0,    16'hA5A5, "R1 read d3");
    req(0, 5'd31, 5'd0,  16'h0,    16'h1357, "R1 read d31");
    req(0, 5'd0,  5'd31, 16'h0,    16'h0F0F, "R1 read d0");

    // R2: upper half claimed, device = address - 16
    set_map(1'b1, 4'b1000);
    req(1, 5'h12, 5'd4, 16'h1234, 16'h0000, "R2 write 0x12");
    req(0, 5'h12, 5'd4, 16'h0,    16'h1234, "R2 read 0x12");
    req(1, 5'h02, 5'd4, 16'h9999, 16'hFFFF, "R4 unclaimed write 0x02");
    req(0, 5'h02, 5'd4, 16'h0,    16'hFFFF, "R4 unclaimed read 0x02");
    req(0, 5'h12, 5'd4, 16'h0,    16'h1234, "R4 no side effect");
    set_map(1'b1, 4'b0111);
    req(0, 5'h02, 5'd4, 16'h0,    16'h1234, "R2 lower half");
    req(0, 5'h12, 5'd4, 16'h0,    16'hFFFF, "R2 upper half unclaimed");
    set_map(1'b0, 4'b0000);
    req(0, 5'd2,  5'd4, 16'h0,    16'h1234, "R2 landed on device 2");

    // R3: indirect window at base 6
    set_map(1'b0, 4'b0011);
    req(0, 5'd6, 5'd0, 16'h0,    16'h0000, "R5 reset command");
    req(0, 5'd6, 5'd1, 16'h0,    16'h0000, "R5 reset data");
    req(0, 5'd7, 5'd0, 16'h0,    16'hFFFF, "R3 odd address");
    req(0, 5'd4, 5'd1, 16'h0,    16'hFFFF, "R3 other base");
    req(0, 5'd6, 5'd2, 16'h0,    16'hFFFF, "R3 reg 2 at base");
    req(0, 5'd3, 5'd7, 16'h0,    16'hFFFF, "R3 no direct path");
    req(1, 5'd6, 5'd2, 16'hABCD, 16'hFFFF, "R4 unclaimed write");
    req(1, 5'd7, 5'd1, 16'hABCD, 16'hFFFF, "R4 unclaimed write");
    req(0, 5'd6, 5'd1, 16'h0,    16'h0000, "R4 data untouched");
    req(0, 5'd6, 5'd0, 16'h0,    16'h0000, "R4 command untouched");

    // R8: indirect write of BEEF to device 5 register 9
    req(1, 5'd6, 5'd1, 16'hBEEF, 16'h0000, "R8 load data");
    req(1, 5'd6, 5'd0, 16'h94A9, 16'h0000, "R6 write command");
    for (int k = 1; k <= LAT; k++)
      req(0, 5'd6, 5'd0, 16'h0, 16'h94A9, "R7 busy set");
    req(0, 5'd6, 5'd0, 16'h0, 16'h14A9, "R7 busy cleared");
    set_map(1'b0, 4'b0000);
    req(0, 5'd5, 5'd9, 16'h0, 16'hBEEF, "R8 target written");
    set_map(1'b0, 4'b0011);

    // R9: indirect read of device 7 register 2
    req(1, 5'd6, 5'd1, 16'h0000, 16'h0000, "R9 clear data");
    req(1, 5'd6, 5'd0, 16'h98E2, 16'h0000, "R6 read command");
    for (int k = 1; k <= LAT; k++)
      req(0, 5'd6, 5'd1, 16'h0, 16'h0000, "R9 data before completion");
    req(0, 5'd6, 5'd1, 16'h0, 16'hC0DE, "R9 data at busy clear");
    req(0, 5'd6, 5'd0, 16'h0, 16'h18E2, "R9 command idle");

    // R10: second command while busy
    req(1, 5'd6, 5'd1, 16'h1111, 16'h0000, "R10 load data");
    req(1, 5'd6, 5'd0, 16'h94A9, 16'h0000, "R10 first command");
    req(1, 5'd6, 5'd0, 16'h98E2, 16'h0000, "R10 command while busy");
    idle(LAT + 1);
    req(0, 5'd6, 5'd0, 16'h0, 16'h14A9, "R10 command kept");
    req(0, 5'd6, 5'd1, 16'h0, 16'h1111, "R10 no read issued");

    // R11: non clause-22 and reserved opcode
    req(1, 5'd6, 5'd1, 16'h2222, 16'h0000, "R11 load data");
    req(1, 5'd6, 5'd0, 16'h84A9, 16'h0000, "R11 non-c22 command");
    for (int k = 1; k <= LAT; k++)
      req(0, 5'd6, 5'd0, 16'h0, 16'h84A9, "R11 busy set");
    req(0, 5'd6, 5'd0, 16'h0, 16'h04A9, "R11 busy cleared");
    req(1, 5'd6, 5'd0, 16'h9CA9, 16'h0000, "R11 opcode 11");
    idle(LAT + 1);
    req(0, 5'd6, 5'd0, 16'h0, 16'h1CA9, "R11 opcode 11 done");
    req(0, 5'd6, 5'd1, 16'h0, 16'h2222, "R11 data untouched");

    // R12: command without busy bit
    req(1, 5'd6, 5'd0, 16'h18E2, 16'h0000, "R12 write no busy");
    req(0, 5'd6, 5'd0, 16'h0,    16'h1CA9, "R12 command unchanged");
    idle(2);
    req(0, 5'd6, 5'd1, 16'h0,    16'h2222, "R12 no read issued");

    set_map(1'b0, 4'b0000);
    req(0, 5'd5, 5'd9, 16'h0, 16'h1111, "R11 target untouched");
    req(0, 5'd7, 5'd2, 16'h0, 16'hC0DE, "R10 read source intact");
    idle(3);

    check(exp_q.size() == 0, "R5 missing responses", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule